// File: doc/BRIEF.md
# Low-Power Sleep and Wakeup Controller

This block decides when a host-interface device drops into a low-power state and when it comes back. Software asks for sleep through a one-cycle request, and an external sleep pin can also ask for it when that pin is enabled. While asleep, the block watches the UART receive line and the sleep pin. Each has its own minimum-duration filter, and only a long enough pulse counts as a wakeup. The block drives only control signals: a power-control output with selectable polarity, a status LED, and the two mode-select lines of a single-wire CAN transceiver. A small status output reports which source ended the last sleep.

The time base is one clock, nominally 16 MHz. Every duration is derived from parameters: clocks per microsecond, microseconds per millisecond, the LED period and the pulse length. Both asynchronous inputs pass through a two-flop synchronizer before any width is measured. Internally there are four states: running, entering sleep, sleeping, and qualifying a wake pulse. A pulse that ends too early sends the controller from qualifying back to sleeping.

Top module: `slp_wake_ctrl`

## Requirements
- R1: Out of reset the block is running. `pwr_ctrl` equals `cfg_pwr_pol`, `led_status` is 1, `wake_src` is 00, and `swc_mode` follows `swc_mode_req`.
- R2: A `sw_sleep_req` high while running moves the block to sleep at that clock edge. The sleep levels on the outputs are visible right after that edge.
- R3: With `cfg_pin_en`=1, a change of the synchronized sleep pin into its active level requests sleep, which takes effect within 3 clocks. `cfg_pin_pol`=0 means active low and 1 means active high. With `cfg_pin_en`=0 the pin requests nothing.
- R4: With `cfg_pwr_pol`=1, `pwr_ctrl` is 1 while running and 0 while not running. With `cfg_pwr_pol`=0 these levels are inverted.
- R5: `swc_mode` is 00 in every non-running state and equals `swc_mode_req` while running.
- R6: `led_status` is 1 while running. Once sleep starts, it stays 0 for LED_PERIOD_MS, then is 1 for LED_ON_MS, and repeats with that period. Counting from the sleep-entry edge, it is first high after edge 1+P and low again after edge 1+P+ON (P and ON in clocks).
- R7: With `cfg_uart_min` below 15, `uart_rx` going low during sleep wakes the block 3 clocks after the change.
- R8: With `cfg_uart_min`=N≥15, `uart_rx` must stay low for N µs. The block then runs 3+N·CYC_PER_US clocks after the fall.
- R9: The pin wakes the block only after it has been seen active during the sleep. It must then stay inactive for 15 µs when `cfg_pin_min`=0, or for N ms when `cfg_pin_min`=N. The block runs 3+T clocks after the change, where T is that time in clocks.
- R10: A wake pulse that ends before its minimum returns the block to sleep with no wakeup.
- R11: `wake_src` bit 0 marks a UART wake and bit 1 marks a pin wake. Both bits are set when both qualify in the same clock. The value holds until the next wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_sleep_req | input | 1 | Software sleep request |
| sleep_pin | input | 1 | Asynchronous external sleep pin |
| uart_rx | input | 1 | Asynchronous UART receive line, idle high |
| cfg_pin_en | input | 1 | Enables sleep requests from the pin |
| cfg_pin_pol | input | 1 | Pin active level (0 low, 1 high) |
| cfg_pwr_pol | input | 1 | Level of `pwr_ctrl` while running |
| cfg_pin_min | input | 16 | Pin wake minimum (0: 15 µs, else ms) |
| cfg_uart_min | input | 16 | UART wake minimum (<15: immediate, else µs) |
| swc_mode_req | input | 2 | Transceiver mode wanted while running |
| pwr_ctrl | output | 1 | External power control |
| led_status | output | 1 | Status LED |
| swc_mode | output | 2 | Transceiver mode-select outputs |
| wake_src | output | 2 | Source of the last wakeup |

## Verification
The UART filter and the pin filter can both reach their minimum in the same clock. The bench provokes this by entering sleep through the pin and setting equal thresholds in clocks: 15 µs for the UART and the pin's 15 µs default. It then lowers `uart_rx` and releases the pin on the same edge. The wake must come exactly 33 clocks later with `wake_src`=11, with neither source pre-empting the other. A scoreboard also times every other wakeup against the latency worked out from R7 to R9. Any wakeup it did not expect is reported, which covers R10.

// File: rtl/slp_pkg.sv
// Shared types and fixed constants of the sleep/wakeup controller.
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_SLEEP = 2'd2,
        ST_QUAL  = 2'd3
    } slp_state_e;

    // default pin wake window when the pin setting is zero, in microseconds
    localparam int PIN_DEF_US  = 15;
    // UART settings below this value mean "any low level wakes"
    localparam int UART_US_MIN = 15;
    // number of wake filters (index 0: UART, index 1: pin)
    localparam int NUM_SRC     = 2;
endpackage

// File: rtl/slp_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes every bit is an independent level; no bus coherence is given.
module slp_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // capture then re-register each asynchronous bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/slp_width_filter.sv
// Minimum-duration filter. Counts how long 'act' has stayed high, in units
// of 'unit_cyc' clocks, and raises 'qual' once 'thr' units have passed.
// thr = 0 qualifies in the first clock that 'act' is high.
// Assumes unit_cyc >= 1; the unit counter saturates at all ones.
module slp_width_filter #(
    parameter int CW = 16,
    parameter int UW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic [CW-1:0] unit_cyc,
    input  logic [UW-1:0] thr,
    output logic          qual
);
    logic [CW-1:0] cyc_q;
    logic [UW-1:0] units_q;

    // measure the current high stretch of 'act'; restart on any low clock
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            cyc_q   <= '0;
            units_q <= '0;
        end else if (units_q != '1) begin
            if (cyc_q >= unit_cyc - 1'b1) begin
                cyc_q   <= '0;
                units_q <= units_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // the stretch has been long enough
    assign qual = act && (units_q >= thr);

    AST_UNITS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> (!act || units_q >= $past(units_q)));  // R8
endmodule

// File: rtl/slp_led_beat.sv
// Sleep heartbeat. While 'en' is high it counts clocks in periods of PERIOD.
// After each complete period it drives 'beat' high for ON clocks.
// Dropping 'en' clears everything, so the first pulse comes one full period
// after 'en' rises. Assumes PERIOD >= 2 and ON < PERIOD.
module slp_led_beat #(
    parameter int PERIOD = 48000000,
    parameter int ON     = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic beat
);
    localparam int PW = $clog2(PERIOD);

    logic [PW-1:0] cnt_q;
    logic          first_q;

    // period counter; first_q marks that at least one period has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (cnt_q == PW'(PERIOD - 1)) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // pulse at the start of each period after the first
    assign beat = first_q && (cnt_q < PW'(ON));

    AST_BEAT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !beat);  // R6
    AST_FIRST_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_q) |-> (cnt_q == '0));  // R6
endmodule

// File: rtl/slp_wake_ctrl.sv
// Low-power sleep and wakeup controller (top).
// Enters sleep on a software request or on an enabled pin edge. Wakes on a
// qualified UART low pulse or a qualified inactive stretch of the sleep pin.
// Drives power control, the status LED and the transceiver mode lines.
// Assumes all cfg_* inputs are quasi-static and uart_rx idles high.
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int CYC_PER_US    = 16,
    parameter int US_PER_MS     = 1000,
    parameter int LED_PERIOD_MS = 3000,
    parameter int LED_ON_MS     = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_sleep_req,
    input  logic        sleep_pin,
    input  logic        uart_rx,
    input  logic        cfg_pin_en,
    input  logic        cfg_pin_pol,
    input  logic        cfg_pwr_pol,
    input  logic [15:0] cfg_pin_min,
    input  logic [15:0] cfg_uart_min,
    input  logic [1:0]  swc_mode_req,
    output logic        pwr_ctrl,
    output logic        led_status,
    output logic [1:0]  swc_mode,
    output logic [1:0]  wake_src
);
    localparam int CYC_PER_MS = CYC_PER_US * US_PER_MS;
    localparam int UCW        = $clog2(CYC_PER_MS + 1);
    localparam int LED_P      = LED_PERIOD_MS * CYC_PER_MS;
    localparam int LED_ON     = LED_ON_MS * CYC_PER_MS;

    slp_state_e state_q, state_d;
    logic [1:0] sync_q;
    logic       pin_s, rx_s, pin_active, pin_prev_q, pin_req, pin_armed_q;
    logic       sleeping, past_ok_q, beat;
    logic       any_act, any_qual;
    logic [NUM_SRC-1:0] f_act, f_qual;
    logic [15:0]        f_thr  [NUM_SRC];
    logic [UCW-1:0]     f_unit [NUM_SRC];

    slp_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sleep_pin, uart_rx}), .q(sync_q)
    );
    assign pin_s = sync_q[1];
    assign rx_s  = sync_q[0];

    assign sleeping   = (state_q != ST_RUN);
    assign pin_active = cfg_pin_pol ? pin_s : ~pin_s;
    assign pin_req    = cfg_pin_en && pin_active && !pin_prev_q;

    // wake filter inputs: UART low level, armed pin at its inactive level
    assign f_act[0] = sleeping && !rx_s;
    assign f_act[1] = sleeping && cfg_pin_en && pin_armed_q && !pin_active;

    // select threshold and unit of each filter from its setting
    always_comb begin
        if (cfg_uart_min < 16'(UART_US_MIN)) f_thr[0] = '0;
        else                                 f_thr[0] = cfg_uart_min;
        f_unit[0] = UCW'(CYC_PER_US);
        if (cfg_pin_min == '0) begin
            f_thr[1]  = 16'(PIN_DEF_US);
            f_unit[1] = UCW'(CYC_PER_US);
        end else begin
            f_thr[1]  = cfg_pin_min;
            f_unit[1] = UCW'(CYC_PER_MS);
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
        slp_width_filter #(.CW(UCW), .UW(16)) u_filt (
            .clk(clk), .rst_n(rst_n), .act(f_act[g]),
            .unit_cyc(f_unit[g]), .thr(f_thr[g]), .qual(f_qual[g])
        );
    end

    assign any_act  = |f_act;
    assign any_qual = |f_qual;

    // next-state decision of the sleep state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sw_sleep_req || pin_req) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_SLEEP;
            ST_SLEEP: if (any_qual)     state_d = ST_RUN;
                      else if (any_act) state_d = ST_QUAL;
            ST_QUAL:  if (any_qual)     state_d = ST_RUN;
                      else if (!any_act) state_d = ST_SLEEP;
            default:  state_d = ST_RUN;
        endcase
    end

    // state, pin edge history, pin arming and wake source registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            pin_prev_q  <= 1'b0;
            pin_armed_q <= 1'b0;
            wake_src    <= 2'b00;
            past_ok_q   <= 1'b0;
        end else begin
            state_q    <= state_d;
            pin_prev_q <= pin_active;
            past_ok_q  <= 1'b1;
            if (!sleeping)       pin_armed_q <= 1'b0;
            else if (pin_active) pin_armed_q <= 1'b1;
            if (sleeping && state_d == ST_RUN) wake_src <= {f_qual[1], f_qual[0]};
        end
    end

    slp_led_beat #(.PERIOD(LED_P), .ON(LED_ON)) u_beat (
        .clk(clk), .rst_n(rst_n), .en(sleeping), .beat(beat)
    );

    // output levels
    assign pwr_ctrl   = sleeping ? ~cfg_pwr_pol : cfg_pwr_pol;
    assign led_status = sleeping ? beat : 1'b1;
    assign swc_mode   = sleeping ? 2'b00 : swc_mode_req;

    AST_ENTER_THEN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |=> (state_q == ST_SLEEP));  // R2
    AST_SW_REQ_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sw_sleep_req) |=> (state_q == ST_ENTER));  // R2
    AST_WAKE_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> (wake_src != 2'b00));  // R11
    AST_WAKE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !any_qual) |=> (state_q != ST_RUN));  // R10
endmodule

// File: tb/sim_slp_wake_ctrl.sv
`timescale 1ns/1ps
module sim_slp_wake_ctrl;
    localparam int CPU = 2;            // clocks per microsecond
    localparam int UPM = 4;            // microseconds per millisecond
    localparam int CPM = CPU * UPM;    // clocks per millisecond
    localparam int LP  = 30 * CPM;     // LED period in clocks
    localparam int LON = 5 * CPM;      // LED pulse in clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_sleep_req = 1'b0, sleep_pin = 1'b1, uart_rx = 1'b1;
    logic cfg_pin_en = 1'b1, cfg_pin_pol = 1'b0, cfg_pwr_pol = 1'b1;
    logic [15:0] cfg_pin_min = '0, cfg_uart_min = '0;
    logic [1:0]  swc_mode_req = 2'b10;
    logic pwr_ctrl, led_status;
    logic [1:0] swc_mode, wake_src;

    int checks = 0, errs = 0;
    int edges = 0;
    bit done = 1'b0;

    typedef struct packed { logic [1:0] src; logic [31:0] lat; logic [31:0] start; } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    slp_wake_ctrl #(.CYC_PER_US(CPU), .US_PER_MS(UPM), .LED_PERIOD_MS(30), .LED_ON_MS(5)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_sleep_req(sw_sleep_req), .sleep_pin(sleep_pin),
        .uart_rx(uart_rx), .cfg_pin_en(cfg_pin_en), .cfg_pin_pol(cfg_pin_pol),
        .cfg_pwr_pol(cfg_pwr_pol), .cfg_pin_min(cfg_pin_min), .cfg_uart_min(cfg_uart_min),
        .swc_mode_req(swc_mode_req), .pwr_ctrl(pwr_ctrl), .led_status(led_status),
        .swc_mode(swc_mode), .wake_src(wake_src)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: remember the stimulus edge count and the expected wake
    task automatic expect_wake(input logic [1:0] src, input int lat);
        exp_t e;
        e.src = src; e.lat = lat; e.start = edges;
        expq.push_back(e);
    endtask

    task automatic sw_sleep();
        sw_sleep_req = 1'b1;
        cyc(1);
        sw_sleep_req = 1'b0;
    endtask

    // monitor: every rise of the running level must match the queue head
    logic prev_run = 1'b1;
    always @(negedge clk) begin
        logic run_now;
        run_now = (pwr_ctrl == cfg_pwr_pol);
        if (rst_n && run_now && !prev_run) begin
            if (expq.size() == 0) begin
                checks++; errs++;
                $display("FAIL R10: unexpected wakeup, actual src %0d expected none", wake_src);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R11 wake source", wake_src, e.src);
                chk("R7/R8/R9 wake latency", edges - e.start, e.lat);
            end
        end
        prev_run = run_now;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 pwr", pwr_ctrl, 1);
        chk("R1 led", led_status, 1);
        chk("R1 wake_src", wake_src, 0);
        chk("R1/R5 swc run", swc_mode, 2'b10);

        // R2, R4, R5, R6: software sleep and heartbeat timing
        sw_sleep_req = 1'b1;
        for (int k = 1; k <= LP + LON + 2; k++) begin
            @(negedge clk);
            sw_sleep_req = 1'b0;
            if (k == 1) begin
                chk("R2/R4 pwr sleep", pwr_ctrl, 0);
                chk("R5 swc sleep", swc_mode, 0);
                chk("R6 led dark", led_status, 0);
            end
            if (k == LP)           chk("R6 led before pulse", led_status, 0);
            if (k == LP + 1)       chk("R6 led pulse start", led_status, 1);
            if (k == LP + LON)     chk("R6 led pulse end", led_status, 1);
            if (k == LP + LON + 1) chk("R6 led after pulse", led_status, 0);
        end

        // R7 immediate UART wake
        cfg_uart_min = 16'd3;
        uart_rx = 1'b0; expect_wake(2'b01, 3);
        cyc(6); uart_rx = 1'b1; cyc(4);
        chk("R6 led running", led_status, 1);

        // R8 UART microsecond window
        sw_sleep(); cyc(3);
        cfg_uart_min = 16'd20;
        uart_rx = 1'b0; expect_wake(2'b01, 3 + 20 * CPU);
        cyc(50); uart_rx = 1'b1; cyc(4);

        // R10 short UART pulse must not wake
        sw_sleep(); cyc(3);
        uart_rx = 1'b0; cyc(20); uart_rx = 1'b1; cyc(80);
        chk("R10 still asleep", pwr_ctrl, 0);

        // R9 pin default window, armed during sleep
        sleep_pin = 1'b0; cyc(6);
        chk("R9 pin active no wake", pwr_ctrl, 0);
        sleep_pin = 1'b1; expect_wake(2'b10, 3 + 15 * CPU);
        cyc(45);

        // R3 pin sleep request, then R9 millisecond window
        sleep_pin = 1'b0; cyc(5);
        chk("R3 pin sleep", pwr_ctrl, 0);
        cfg_pin_min = 16'd2;
        sleep_pin = 1'b1; expect_wake(2'b10, 3 + 2 * CPM);
        cyc(30);

        // R3 disabled pin requests nothing
        cfg_pin_en = 1'b0; sleep_pin = 1'b0; cyc(10);
        chk("R3 pin disabled", pwr_ctrl, 1);
        sleep_pin = 1'b1; cyc(4);

        // R3 active-high pin polarity
        cfg_pin_pol = 1'b1; cyc(4);
        sleep_pin = 1'b0; cyc(4);
        cfg_pin_en = 1'b1; cyc(2);
        sleep_pin = 1'b1; cyc(5);
        chk("R3 pin active high sleep", pwr_ctrl, 0);
        cfg_pin_min = 16'd0;
        sleep_pin = 1'b0; expect_wake(2'b10, 3 + 15 * CPU);
        cyc(45);
        cfg_pin_en = 1'b0; cfg_pin_pol = 1'b0; cyc(2);
        sleep_pin = 1'b1; cyc(4);
        cfg_pin_en = 1'b1; cyc(2);

        // R11 both sources qualify in the same clock
        sleep_pin = 1'b0; cyc(6);
        chk("R3 pin sleep again", pwr_ctrl, 0);
        cfg_uart_min = 16'd15;
        sleep_pin = 1'b1; uart_rx = 1'b0; expect_wake(2'b11, 3 + 15 * CPU);
        cyc(40); uart_rx = 1'b1; cyc(4);

        // R4 inverted power polarity
        cfg_pwr_pol = 1'b0; cyc(2);
        chk("R4 inverted run", pwr_ctrl, 0);
        sw_sleep(); cyc(2);
        chk("R4 inverted sleep", pwr_ctrl, 1);
        cfg_uart_min = 16'd0;
        uart_rx = 1'b0; expect_wake(2'b01, 3);
        cyc(6); uart_rx = 1'b1; cyc(4);
        chk("R5 swc back", swc_mode, 2'b10);

        cyc(4);
        checks++;
        if (expq.size() != 0) begin
            errs++;
            $display("FAIL R11: actual %0d wakes missing expected 0", expq.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule